// File: doc/BRIEF.md
# Stall-Only Read-After-Write Interlock

This block guards the decode stage of a five-stage in-order pipeline that has no bypass paths. Each cycle it compares the two source register names of the instruction waiting in decode against the destination names of the two older instructions in the execute and memory stages. If any comparison hits, the older instruction has not yet written its result back, so the consumer must wait.

The block resolves every such dependence by stalling. During a stall it deasserts the program-counter write enable and the fetch/decode register write enable, so the waiting instruction and its fetch address stay in place. It also raises a bubble signal, which tells the control staging logic to clear every control line it passes from decode onward. An instruction that has reached write-back needs no comparison, because the register file writes in the first half of a cycle and reads in the second.

The block holds no state. A producer that is one instruction ahead gives two stall cycles without a counter. The hit is seen first against the execute stage. On the next cycle the same producer sits in the memory stage, and the hit is seen again there. A producer two instructions ahead is seen only in the memory stage, so it costs one stall cycle.

Top module: `raw_stall_unit`

## Requirements
- R1: When `ex_wr` is 1, `ex_dst` is nonzero and `ex_dst` equals either source name, the block stalls. A stall means `bubble`=1, `pc_we`=0 and `ifid_we`=0.
- R2: When `mem_wr` is 1, `mem_dst` is nonzero and `mem_dst` equals either source name, the block stalls.
- R3: When neither destination equals either source name, the block does not stall. No stall means `bubble`=0, `pc_we`=1 and `ifid_we`=1. There is no write-back input, so a producer that has reached write-back never stalls.
- R4: Register name 0 never causes a stall, even when a write flag is set and the names match.
- R5: A destination whose write flag is 0 is ignored, even when it matches a source name.
- R6: Source A and source B are each checked against each producer. A hit on either source alone is enough to stall.
- R7: `pc_we` and `ifid_we` are always equal to each other and always the inverse of `bubble`.
- R8: A producer directly ahead of the consumer gives two consecutive stall cycles: one while the producer is in execute and one while it is in memory. A producer two ahead gives exactly one stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | 5 | First source register name of the decode instruction |
| id_src_b | input | 5 | Second source register name of the decode instruction |
| ex_dst | input | 5 | Destination name of the instruction in execute |
| ex_wr | input | 1 | Register-write flag of the instruction in execute |
| mem_dst | input | 5 | Destination name of the instruction in memory |
| mem_wr | input | 1 | Register-write flag of the instruction in memory |
| pc_we | output | 1 | Program counter write enable; 0 holds fetch |
| ifid_we | output | 1 | Fetch/decode register write enable; 0 holds decode |
| bubble | output | 1 | 1 zeroes control lines from decode onward |

## Verification
The hardest case to reach from the ports is the two-cycle stall. It needs the same producer to appear first in execute, then in memory with a bubble behind it in execute. Meanwhile the consumer must stay unchanged in decode. The bench replays that sequence cycle by cycle: it moves the producer and inserts the bubble, exactly as the surrounding pipeline would. It then checks that the stall holds for two cycles and releases once the producer leaves memory. A second sequence starts with the producer in memory and checks that the stall lasts one cycle.

// File: rtl/hzd_pkg.sv
// Package: shared widths and counts for the stall-only interlock.
// Assumes a register file addressed by REG_ADDR_W bits, where name 0 is constant.
package hzd_pkg;
    localparam int REG_ADDR_W = 5;
    localparam int NUM_SRC    = 2;   // source operands per decoded instruction
    localparam int NUM_PROD   = 2;   // producer stages checked: execute, memory
    typedef logic [REG_ADDR_W-1:0] reg_name_t;
endpackage

// File: rtl/hzd_src_cmp.sv
// Module: compares one source name against one producer destination.
// Assumes name 0 is a constant register that never needs interlock.
module hzd_src_cmp
    import hzd_pkg::*;
(
    input  reg_name_t src,
    input  reg_name_t dst,
    input  logic      wr,
    output logic      hit
);
    localparam reg_name_t ZERO_NAME = '0;

    // Hit only for a real, writing producer of a nonzero name.
    always_comb begin
        hit = wr && (dst != ZERO_NAME) && (dst == src);
    end

    // Guard the zero-name and write-flag rules next to the comparator.
    always_comb begin
        if (src == ZERO_NAME) begin
            assert_zero_name_quiet_R4: assert (!hit)
                else $error("R4: register 0 produced a hit");
        end
        if (!wr) begin
            assert_nowrite_ignored_R5: assert (!hit)
                else $error("R5: non-writing producer produced a hit");
        end
    end
endmodule

// File: rtl/hzd_stage_probe.sv
// Module: checks every source operand against one producer stage.
// Assumes the sources arrive as a packed array, one name per operand.
module hzd_stage_probe
    import hzd_pkg::*;
#(
    parameter int NSRC = NUM_SRC
) (
    input  reg_name_t [NSRC-1:0] srcs,
    input  reg_name_t            dst,
    input  logic                 wr,
    output logic                 stage_hit
);
    logic [NSRC-1:0] per_src;

    // One comparator per source operand.
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        hzd_src_cmp u_cmp (
            .src (srcs[s]),
            .dst (dst),
            .wr  (wr),
            .hit (per_src[s])
        );
    end

    // Any operand hit makes this stage a hazard.
    always_comb begin
        stage_hit = |per_src;
    end

    // Any single operand hit must reach the stage output.
    always_comb begin
        if (per_src != '0) begin
            assert_any_operand_hits_R6: assert (stage_hit)
                else $error("R6: operand hit lost in stage reduction");
        end
    end
endmodule

// File: rtl/hzd_stall_gen.sv
// Module: turns per-stage hazard flags into hold and bubble controls.
// Assumes the stage flags are combinational for the current decode cycle.
module hzd_stall_gen
    import hzd_pkg::*;
#(
    parameter int NPROD = NUM_PROD
) (
    input  logic [NPROD-1:0] stage_hits,
    output logic             pc_we,
    output logic             ifid_we,
    output logic             bubble
);
    logic stall;

    // A hazard in any producer stage stalls decode.
    always_comb begin
        stall = |stage_hits;
    end

    // Hold fetch and decode, and zero control lines downstream, while stalled.
    always_comb begin
        pc_we   = !stall;
        ifid_we = !stall;
        bubble  = stall;
    end
endmodule

// File: rtl/raw_stall_unit.sv
// Module: top of the stall-only read-after-write interlock.
// Assumes there is no bypass network and that the register file writes
// before it reads within one cycle, so write-back is never compared.
module raw_stall_unit
    import hzd_pkg::*;
(
    input  logic [REG_ADDR_W-1:0] id_src_a,
    input  logic [REG_ADDR_W-1:0] id_src_b,
    input  logic [REG_ADDR_W-1:0] ex_dst,
    input  logic                  ex_wr,
    input  logic [REG_ADDR_W-1:0] mem_dst,
    input  logic                  mem_wr,
    output logic                  pc_we,
    output logic                  ifid_we,
    output logic                  bubble
);
    localparam int P_EX  = 0;
    localparam int P_MEM = 1;

    reg_name_t [NUM_SRC-1:0]  srcs;
    reg_name_t [NUM_PROD-1:0] dsts;
    logic      [NUM_PROD-1:0] wrs;
    logic      [NUM_PROD-1:0] stage_hits;

    // Gather operands and producers into indexed arrays.
    always_comb begin
        srcs[0]     = id_src_a;
        srcs[1]     = id_src_b;
        dsts[P_EX]  = ex_dst;
        dsts[P_MEM] = mem_dst;
        wrs[P_EX]   = ex_wr;
        wrs[P_MEM]  = mem_wr;
    end

    // One probe per producer stage.
    for (genvar p = 0; p < NUM_PROD; p++) begin : g_stage
        hzd_stage_probe #(.NSRC(NUM_SRC)) u_probe (
            .srcs      (srcs),
            .dst       (dsts[p]),
            .wr        (wrs[p]),
            .stage_hit (stage_hits[p])
        );
    end

    hzd_stall_gen #(.NPROD(NUM_PROD)) u_gen (
        .stage_hits (stage_hits),
        .pc_we      (pc_we),
        .ifid_we    (ifid_we),
        .bubble     (bubble)
    );

    // Port-level checks of the stall decision.
    always_comb begin
        assert_hold_lines_agree_R7: assert ((pc_we == ifid_we) && (pc_we == !bubble))
            else $error("R7: hold and bubble controls disagree");
        if (ex_wr && ex_dst != '0 && (ex_dst == id_src_a || ex_dst == id_src_b)) begin
            assert_ex_match_stalls_R1: assert (bubble)
                else $error("R1: execute-stage match did not stall");
        end
        if (mem_wr && mem_dst != '0 && (mem_dst == id_src_a || mem_dst == id_src_b)) begin
            assert_mem_match_stalls_R2: assert (bubble)
                else $error("R2: memory-stage match did not stall");
        end
        if (ex_dst != id_src_a && ex_dst != id_src_b &&
            mem_dst != id_src_a && mem_dst != id_src_b) begin
            assert_no_match_no_stall_R3: assert (!bubble)
                else $error("R3: stall without any name match");
        end
    end
endmodule

// File: tb/tb_raw_stall_unit.sv
module tb_raw_stall_unit;
    logic       clk = 1'b0;
    logic [4:0] id_src_a, id_src_b, ex_dst, mem_dst;
    logic       ex_wr, mem_wr;
    logic       pc_we, ifid_we, bubble;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    raw_stall_unit dut (
        .id_src_a (id_src_a), .id_src_b (id_src_b),
        .ex_dst   (ex_dst),   .ex_wr    (ex_wr),
        .mem_dst  (mem_dst),  .mem_wr   (mem_wr),
        .pc_we    (pc_we),    .ifid_we  (ifid_we),
        .bubble   (bubble)
    );

    // Vector: {src_a, src_b, ex_dst, ex_wr, mem_dst, mem_wr, expected_stall}
    localparam int NV = 14;
    localparam logic [22:0] VEC [NV] = '{
        {5'd3, 5'd4, 5'd3, 1'b1, 5'd9, 1'b0, 1'b1},  // R1 src a vs ex
        {5'd3, 5'd4, 5'd4, 1'b1, 5'd9, 1'b0, 1'b1},  // R1 R6 src b vs ex
        {5'd7, 5'd8, 5'd1, 1'b1, 5'd7, 1'b1, 1'b1},  // R2 src a vs mem
        {5'd7, 5'd8, 5'd1, 1'b0, 5'd8, 1'b1, 1'b1},  // R2 R6 src b vs mem
        {5'd5, 5'd6, 5'd1, 1'b1, 5'd2, 1'b1, 1'b0},  // R3 no match
        {5'd0, 5'd6, 5'd0, 1'b1, 5'd0, 1'b1, 1'b0},  // R4 zero everywhere
        {5'd6, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 1'b0},  // R4 zero producer
        {5'd3, 5'd4, 5'd3, 1'b0, 5'd4, 1'b0, 1'b0},  // R5 flags clear
        {5'd3, 5'd3, 5'd3, 1'b0, 5'd9, 1'b1, 1'b0},  // R5 ex masked
        {5'd3, 5'd4, 5'd3, 1'b1, 5'd4, 1'b1, 1'b1},  // R1 R2 both
        {5'd31, 5'd2, 5'd31, 1'b1, 5'd0, 1'b0, 1'b1},// R1 top name
        {5'd12, 5'd12, 5'd9, 1'b1, 5'd12, 1'b1, 1'b1},// R2 R6 same src
        {5'd12, 5'd13, 5'd14, 1'b1, 5'd15, 1'b1, 1'b0},// R3 near names
        {5'd1, 5'd2, 5'd2, 1'b0, 5'd1, 1'b0, 1'b0}   // R5 both masked
    };

    task automatic check(input bit exp_stall, input string req);
        n_cmp++;
        if (bubble !== exp_stall || pc_we !== !exp_stall || ifid_we !== !exp_stall) begin
            n_bad++;
            $display("FAIL %s: bubble=%0b pc_we=%0b ifid_we=%0b expected bubble=%0b",
                     req, bubble, pc_we, ifid_we, exp_stall);
        end
    endtask

    task automatic drive(input logic [4:0] a, input logic [4:0] b,
                         input logic [4:0] ed, input logic ew,
                         input logic [4:0] md, input logic mw);
        @(negedge clk);
        id_src_a = a; id_src_b = b; ex_dst = ed; ex_wr = ew;
        mem_dst = md; mem_wr = mw;
        #1;
    endtask

    initial begin
        id_src_a = '0; id_src_b = '0; ex_dst = '0; ex_wr = 1'b0;
        mem_dst = '0; mem_wr = 1'b0;
        // Idle pipeline after reset: no stall (R3, R7).
        drive(5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0);
        check(1'b0, "R3 idle");

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][22:18], VEC[i][17:13], VEC[i][12:8], VEC[i][7],
                  VEC[i][6:2], VEC[i][1]);
            check(VEC[i][0], $sformatf("R1-table vector %0d (R7)", i));
        end

        // R8: producer directly ahead -> two stall cycles, then release.
        drive(5'd10, 5'd11, 5'd10, 1'b1, 5'd20, 1'b1);
        check(1'b1, "R8 adjacent cycle 1");
        drive(5'd10, 5'd11, 5'd0, 1'b0, 5'd10, 1'b1);   // bubble now in execute
        check(1'b1, "R8 adjacent cycle 2");
        drive(5'd10, 5'd11, 5'd0, 1'b0, 5'd0, 1'b0);    // producer in write-back
        check(1'b0, "R8 adjacent release (R3)");

        // R8: producer two ahead -> one stall cycle.
        drive(5'd17, 5'd18, 5'd25, 1'b1, 5'd18, 1'b1);
        check(1'b1, "R8 distance-two cycle 1");
        drive(5'd17, 5'd18, 5'd0, 1'b0, 5'd25, 1'b1);
        check(1'b0, "R8 distance-two release");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule